// File: doc/BRIEF.md
# Two-Register 16-Bit Processor Core

A small single-cycle load/store core with a 16-bit datapath, two general registers and word addressing over a 64K-word space. Every clock it presents the program counter on an instruction port and decodes the 16-bit word that comes back. It then updates one register, the PC or the data memory in that same cycle. Both memory ports are read combinationally: the surrounding system returns instruction and data words within the cycle, and a store is committed on the rising edge while the write strobe is high.

Each register specifier is a single bit, so I-format words carry a 10-bit signed immediate and J-format words carry a 12-bit target within the current 4K-word page. Opcodes that are not assigned behave as no-ops. Both registers are brought out as ports so that the surrounding system can observe them.

Top module: `tworeg_cpu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the PC (`imem_addr`), `reg0` and `reg1` are all zero.
- R2: Field layout: opcode in bits [15:12], source select `rs` in bit 11, target select `rt` in bit 10, R-format destination select `rd` in bit 9, immediate/offset in bits [9:0] (sign-extended to 16 bits), jump target in bits [11:0]. A select value of 0 names `reg0` and 1 names `reg1`. Every instruction other than a taken branch or a jump advances the PC by one.
- R3: Opcode 0x1 writes the `rd` register with `rs` op `rt`, where bits [1:0] select the operation: 00 add, 01 subtract (rs - rt), 10 AND, 11 OR. The operations wrap modulo 2^16.
- R4: Opcodes 0x8, 0x9, 0xA and 0xB write the `rt` register with `rs` plus, minus, AND or OR the sign-extended immediate.
- R5: Opcode 0x2 writes `rt` with `rs` shifted left by one bit. Opcode 0x3 writes `rt` with `rs` shifted right logically by one bit.
- R6: Opcode 0x4 (load) drives `dmem_addr` = `rs` + sext(imm) and writes `rt` with `dmem_rdata` in the same cycle. For example, 0x4B23 loads `reg0` from `reg1` + 0xFF23.
- R7: Opcode 0x5 (store) drives `dmem_we` high with `dmem_addr` = `rs` + sext(imm) and `dmem_wdata` = `rt`, and leaves both registers unchanged. `dmem_we` is low for every other opcode.
- R8: Opcode 0x6 (branch) sets PC = PC + 1 + sext(imm) when `reg0` equals `reg1`, and PC = PC + 1 otherwise. Registers are unchanged.
- R9: Opcode 0x7 (jump) sets PC = {PC[15:12], target[11:0]} and leaves the registers unchanged.
- R10: Opcodes 0x0 and 0xC to 0xF change neither register nor memory and advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 16 | Program counter, the instruction fetch address |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 16 | Data memory word address |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe; the write occurs at the rising edge |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, valid in the same cycle |
| reg0 | output | 16 | Contents of register 0 |
| reg1 | output | 16 | Contents of register 1 |

## Verification
The bench targets five corner cases. A taken branch with the most negative offset wraps the PC into the top page; a design that zero-extended the offset would land near address 0x200 instead. A following jump must keep page 0xF, and a design that cleared the upper PC nibble would fetch from page 0. Loads whose immediate has bit 9 set must reach a wrapped address, and a design that swapped the `rs` and `rt` roles would store or reload the wrong register. Reserved opcodes and branches that are not taken must leave both registers untouched. Any stray write shows up on the register ports in the following cycle.

// File: rtl/tworeg_cpu.sv
module tworeg_cpu (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] imem_addr,
  input  logic [15:0] imem_data,
  output logic [15:0] dmem_addr,
  output logic [15:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [15:0] dmem_rdata,
  output logic [15:0] reg0,
  output logic [15:0] reg1
);

  logic [15:0] pc, r0, r1;
  logic [15:0] rs_val, rt_val, imm, res, next_pc, seq_pc;
  logic [3:0]  op;
  logic        wr_en, wr_sel;

  assign op     = imem_data[15:12];
  assign rs_val = imem_data[11] ? r1 : r0;
  assign rt_val = imem_data[10] ? r1 : r0;
  assign imm    = {{6{imem_data[9]}}, imem_data[9:0]};
  assign seq_pc = pc + 16'd1;

  assign dmem_addr  = rs_val + imm;
  assign dmem_wdata = rt_val;
  assign dmem_we    = (op == 4'h5);

  always_comb begin
    res     = '0;
    wr_en   = 1'b0;
    wr_sel  = imem_data[10];
    next_pc = seq_pc;
    case (op)
      4'h1: begin
        wr_en  = 1'b1;
        wr_sel = imem_data[9];
        case (imem_data[1:0])
          2'b00: res = rs_val + rt_val;
          2'b01: res = rs_val - rt_val;
          2'b10: res = rs_val & rt_val;
          default: res = rs_val | rt_val;
        endcase
      end
      4'h2: begin wr_en = 1'b1; res = {rs_val[14:0], 1'b0}; end
      4'h3: begin wr_en = 1'b1; res = {1'b0, rs_val[15:1]}; end
      4'h4: begin wr_en = 1'b1; res = dmem_rdata; end
      4'h6: if (r0 == r1) next_pc = seq_pc + imm;
      4'h7: next_pc = {pc[15:12], imem_data[11:0]};
      4'h8: begin wr_en = 1'b1; res = rs_val + imm; end
      4'h9: begin wr_en = 1'b1; res = rs_val - imm; end
      4'hA: begin wr_en = 1'b1; res = rs_val & imm; end
      4'hB: begin wr_en = 1'b1; res = rs_val | imm; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      r0 <= '0;
      r1 <= '0;
    end else begin
      pc <= next_pc;
      if (wr_en && !wr_sel) r0 <= res;
      if (wr_en &&  wr_sel) r1 <= res;
    end
  end

  assign imem_addr = pc;
  assign reg0      = r0;
  assign reg1      = r1;

  a_r10_nop_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h0 || op >= 4'hC) |=> (reg0 == $past(reg0) && reg1 == $past(reg1)
                                    && imem_addr == $past(imem_addr) + 16'd1));

  a_r9_jump_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h7) |=> (imem_addr[15:12] == $past(imem_addr[15:12])
                      && reg0 == $past(reg0) && reg1 == $past(reg1)));

  a_r8_branch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h6 && reg0 != reg1) |=> (imem_addr == $past(imem_addr) + 16'd1));

  a_r7_store_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> (reg0 == $past(reg0) && reg1 == $past(reg1)));

  a_r8_branch_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h6) |=> $stable(reg0) && $stable(reg1));

endmodule

// File: tb/test_tworeg_cpu.sv
`timescale 1ns/1ps
module test_tworeg_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, reg0, reg1;
  logic        dmem_we;

  logic [15:0] imem [0:255];
  logic [15:0] dmem [0:255];
  logic [15:0] mdm  [0:255];
  logic [15:0] mpc, mr0, mr1;
  string       prevtag;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  tworeg_cpu i_tworeg_cpu (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .reg0(reg0), .reg1(reg1));

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h1: return "R3";
      4'h2, 4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h6: return "R8";
      4'h7: return "R9";
      4'h8, 4'h9, 4'hA, 4'hB: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic step_model();
    logic [15:0] ins, rs, rt, imm, res, addr;
    logic        we, sel;
    ins = imem[mpc[7:0]];
    rs  = ins[11] ? mr1 : mr0;
    rt  = ins[10] ? mr1 : mr0;
    imm = {{6{ins[9]}}, ins[9:0]};
    addr = rs + imm;
    we = 1'b1; sel = ins[10]; res = '0;
    case (ins[15:12])
      4'h1: begin
        sel = ins[9];
        res = (ins[1:0] == 2'd0) ? rs + rt : (ins[1:0] == 2'd1) ? rs - rt :
              (ins[1:0] == 2'd2) ? (rs & rt) : (rs | rt);
      end
      4'h2: res = rs << 1;
      4'h3: res = rs >> 1;
      4'h4: res = mdm[addr[7:0]];
      4'h8: res = rs + imm;
      4'h9: res = rs - imm;
      4'hA: res = rs & imm;
      4'hB: res = rs | imm;
      default: we = 1'b0;
    endcase
    if (ins[15:12] == 4'h5) mdm[addr[7:0]] = rt;
    if (ins[15:12] == 4'h6 && mr0 == mr1) mpc = mpc + 16'd1 + imm;
    else if (ins[15:12] == 4'h7) mpc = {mpc[15:12], ins[11:0]};
    else mpc = mpc + 16'd1;
    if (we) begin
      if (sel) mr1 = res; else mr0 = res;
    end
    prevtag = tag_of(ins[15:12]);
  endtask

  task automatic cycle();
    logic [15:0] ins, rs, imm;
    string t;
    ins = imem[mpc[7:0]];
    t = tag_of(ins[15:12]);
    chk((prevtag == "R8" || prevtag == "R9") ? prevtag : {"R2/", prevtag}, "pc", imem_addr, mpc);
    chk(prevtag, "reg0", reg0, mr0);
    chk(prevtag, "reg1", reg1, mr1);
    chk("R7", "dmem_we", {15'd0, dmem_we}, {15'd0, ins[15:12] == 4'h5});
    if (ins[15:12] == 4'h4 || ins[15:12] == 4'h5) begin
      rs  = ins[11] ? mr1 : mr0;
      imm = {{6{ins[9]}}, ins[9:0]};
      chk(t, "dmem_addr", dmem_addr, rs + imm);
      if (ins[15:12] == 4'h5) chk("R7", "dmem_wdata", dmem_wdata, ins[10] ? mr1 : mr0);
    end
    step_model();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin dmem[i] = 16'(i * 7); mdm[i] = 16'(i * 7); end
    mpc = '0; mr0 = '0; mr1 = '0; prevtag = "R1";
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 16'h0000);
    chk("R1", "reg0 in reset", reg0, 16'h0000);
    chk("R1", "reg1 in reset", reg1, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] rand_ins();
    logic [31:0] r;
    r = $urandom;
    if (r[2:0] == 3'd0) return 16'h1203;
    return r[31:16];
  endfunction

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2006));
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
    imem[8'h00] = 16'h1001; imem[8'h01] = 16'h1E01;
    imem[8'h02] = 16'h8002; imem[8'h03] = 16'h8C03;
    imem[8'h04] = 16'h1400; imem[8'h05] = 16'h5810;
    imem[8'h06] = 16'h4C10; imem[8'h07] = 16'h6200;
    imem[8'h08] = 16'h7123; imem[8'h23] = 16'h93FF;
    imem[8'h24] = 16'h2400; imem[8'h25] = 16'h3800;
    imem[8'h26] = 16'hA3FE; imem[8'h27] = 16'hBC01;
    imem[8'h28] = 16'h6005; imem[8'h29] = 16'hC000;
    imem[8'h2A] = 16'hF0FF; imem[8'h2B] = 16'h4B23;
    do_reset();
    for (int k = 0; k < 5; k++) cycle();
    chk("R3", "directed add result", reg0, 16'h0005);
    cycle();
    chk("R7", "stored word at 0x13", dmem[8'h13], 16'h0005);
    cycle();
    chk("R6", "loaded word", reg1, 16'h0005);
    cycle();
    chk("R8", "taken branch with offset -512", imem_addr, 16'hFE08);
    cycle();
    chk("R9", "jump keeps page F", imem_addr, 16'hF123);
    cycle();
    chk("R4", "subi by -1", reg0, 16'h0006);
    cycle();
    chk("R5", "shift left", reg1, 16'h000C);
    cycle();
    chk("R5", "shift right", reg0, 16'h0006);
    cycle(); cycle();
    chk("R4", "ori", reg1, 16'h000D);
    cycle();
    chk("R8", "untaken branch", imem_addr, 16'hF129);
    cycle(); cycle();
    chk("R10", "reserved opcodes keep reg0", reg0, 16'h0006);
    chk("R10", "reserved opcodes keep reg1", reg1, 16'h000D);
    cycle();
    chk("R6", "load with negative offset", reg0, 16'(8'h30 * 7));
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 256; i++) imem[i] = rand_ins();
      do_reset();
      for (int k = 0; k < 3000; k++) cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule